// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Control with Ready Signalling

This block is the FIFO-control slice of one UART channel. It takes byte writes to a FIFO control register. From those writes it holds the FIFO enable, the ready-signalling select and the receive trigger code. Two of the register bits are self-clearing flush commands. The block keeps an occupancy counter for the receive FIFO and one for the transmit FIFO. Push and pop pulses from the surrounding datapath move each counter.

From the occupancy, the block drives two active-low ready outputs for a DMA engine or host. These are `rxRdyN` and `txRdyN`, and they work in one of two signalling styles. In single-character style, the outputs report "something to read" and "transmitter completely idle". In block style, the receive output waits for the trigger level or a timeout, and the transmit output reports any free slot. A level flag also tells the interrupt logic that the receive trigger has been reached.

The serial shift registers, the baud generation and the character-timeout timer lie outside the block. So does interrupt identification. `holdBusy` and `rxTimeout` arrive as inputs.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both counts are 0, the register reads 0x00, single-character style is active, `txRdyN` is 0 and `rxRdyN` is 1.
- R2: A push is accepted only when the count is below DEPTH (16), and a pop only when the count is nonzero. Accepted pushes add 1 and accepted pops subtract 1 at the next clock edge, so a push and a pop together leave a middle count unchanged.
- R3: A write with data bit 1 set makes the receive count 0 at that edge. This overrides any receive push or pop in the same cycle and leaves the transmit count alone.
- R4: A write with data bit 2 set makes the transmit count 0 at that edge. This overrides any transmit push or pop in the same cycle and leaves the receive count alone.
- R5: Register readback is {trigger code[7:6], 0, 0, select bit 3, 0, 0, enable bit 0}. Bits 1, 2, 4 and 5 always read 0 and bits 4 and 5 have no effect. A write with bits 1 and 2 clear leaves both counts unchanged.
- R6: The trigger code in bits 7:6 selects a level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `rxTrigHit` is 1 exactly when the FIFOs are enabled and the receive count is at least that level.
- R7: In single-character style, `txRdyN` is 0 exactly when the transmit count is 0 and `holdBusy` is 0.
- R8: In single-character style, `rxRdyN` is 0 exactly when the receive count is nonzero.
- R9: Block style is active only when enable (bit 0) and select (bit 3) are both 1. In block style, `txRdyN` is 1 exactly when the transmit count equals DEPTH.
- R10: In block style, `rxRdyN` falls as soon as the receive count reaches the trigger level. It also falls after any clock edge that samples `rxTimeout` high while the count is nonzero. Once low, it stays low until the receive count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write data |
| cfgRdData | output | 8 | Control register readback |
| rxPush | input | 1 | Character written into receive FIFO |
| rxPop | input | 1 | Character read out of receive FIFO |
| txPush | input | 1 | Character written into transmit FIFO |
| txPop | input | 1 | Character moved from transmit FIFO to holding register |
| holdBusy | input | 1 | Transmit holding register occupied |
| rxTimeout | input | 1 | Receive character timeout flagged |
| rxCount | output | CNT_W (5) | Receive FIFO occupancy |
| txCount | output | CNT_W (5) | Transmit FIFO occupancy |
| rxTrigHit | output | 1 | Receive count at or above trigger level |
| rxRdyN | output | 1 | Active-low receive ready |
| txRdyN | output | 1 | Active-low transmit ready |

## Verification
Two things can land on the same edge: a flush command from a register write, and a push or pop on the counter that the flush targets. The bench provokes this by asserting both flush bits together with receive and transmit pushes in one cycle. The test passes only if both counts read 0 after that edge. The bench also pushes and pops together at a full transmit FIFO, where the result must be one below full.

// File: rtl/fifoctl_pkg.sv
package fifoctl_pkg;

  typedef struct packed {
    logic rxFlush;
    logic txFlush;
  } flushStrobe_t;

  typedef enum logic {
    SIG_CHAR  = 1'b0,
    SIG_BLOCK = 1'b1
  } rdyMode_e;

  function automatic logic [7:0] trigLevel(input logic [1:0] code);
    case (code)
      2'b00:   trigLevel = 8'd1;
      2'b01:   trigLevel = 8'd4;
      2'b10:   trigLevel = 8'd8;
      default: trigLevel = 8'd14;
    endcase
  endfunction

endpackage

// File: rtl/fifoctl_occ.sv
module fifoctl_occ #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic pushOk;
  logic popOk;

  assign pushOk = push && (count != FULL_CNT);
  assign popOk  = pop && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (flush) begin
      count <= '0;
    end else if (pushOk && !popOk) begin
      count <= count + 1'b1;
    end else if (popOk && !pushOk) begin
      count <= count - 1'b1;
    end
  end

  // R2: occupancy never exceeds the FIFO depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R2: a pop on an empty FIFO leaves it empty
  a_r2_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !push && !flush) |=> count == '0);

  // R3/R4: a flush beats any push or pop in the same cycle
  a_r3_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);

endmodule

// File: rtl/fifoctl_ctrl.sv
module fifoctl_ctrl
  import fifoctl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic [7:0]   wrData,
  output flushStrobe_t flushStb,
  output logic         fifoOn,
  output rdyMode_e     rdyMode,
  output logic [1:0]   trigCode,
  output logic [7:0]   rdData
);

  logic fifoOnQ;
  logic blockSelQ;
  logic [1:0] trigQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifoOnQ   <= 1'b0;
      blockSelQ <= 1'b0;
      trigQ     <= 2'b00;
    end else if (wrEn) begin
      fifoOnQ   <= wrData[0];
      blockSelQ <= wrData[3];
      trigQ     <= wrData[7:6];
    end
  end

  always_comb begin
    flushStb.rxFlush = wrEn && wrData[1];
    flushStb.txFlush = wrEn && wrData[2];
  end

  assign fifoOn   = fifoOnQ;
  assign trigCode = trigQ;
  assign rdyMode  = (fifoOnQ && blockSelQ) ? SIG_BLOCK : SIG_CHAR;
  assign rdData   = {trigQ, 2'b00, blockSelQ, 2'b00, fifoOnQ};

  // R9: writing enable and select together selects block style next cycle
  a_r9_mode_select: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[0] && wrData[3]) |=> rdyMode == SIG_BLOCK);

  // R9: clearing enable always falls back to single-character style
  a_r9_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrData[0]) |=> rdyMode == SIG_CHAR);

endmodule

// File: rtl/fifoctl_data.sv
module fifoctl_data
  import fifoctl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  flushStrobe_t  flushStb,
  input  logic          fifoOn,
  input  rdyMode_e      rdyMode,
  input  logic [1:0]    trigCode,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          holdBusy,
  input  logic          rxTimeout,
  output logic [CW-1:0] rxCount,
  output logic [CW-1:0] txCount,
  output logic          rxTrigHit,
  output logic          rxRdyN,
  output logic          txRdyN
);

  localparam int NCH = 2;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [NCH-1:0] pushV;
  logic [NCH-1:0] popV;
  logic [NCH-1:0] flushV;
  logic [CW-1:0]  cntV [NCH];

  assign pushV  = {txPush, rxPush};
  assign popV   = {txPop, rxPop};
  assign flushV = {flushStb.txFlush, flushStb.rxFlush};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_occ
    fifoctl_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (pushV[ch]),
      .pop   (popV[ch]),
      .flush (flushV[ch]),
      .count (cntV[ch])
    );
  end

  assign rxCount = cntV[0];
  assign txCount = cntV[1];

  logic [7:0]    levelFull;
  logic [CW-1:0] rxLevel;
  logic          rxAtLevel;
  logic          rxArmedQ;
  logic          rxNonEmpty;

  assign levelFull  = trigLevel(trigCode);
  assign rxLevel    = levelFull[CW-1:0];
  assign rxNonEmpty = (rxCount != '0);
  assign rxAtLevel  = (rxCount >= rxLevel);
  assign rxTrigHit  = fifoOn && rxAtLevel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxArmedQ <= 1'b0;
    end else if (!rxNonEmpty) begin
      rxArmedQ <= 1'b0;
    end else if (rxAtLevel || rxTimeout) begin
      rxArmedQ <= 1'b1;
    end
  end

  always_comb begin
    if (rdyMode == SIG_BLOCK) begin
      rxRdyN = !(rxNonEmpty && (rxArmedQ || rxAtLevel));
      txRdyN = (txCount == FULL_CNT);
    end else begin
      rxRdyN = !rxNonEmpty;
      txRdyN = !((txCount == '0) && !holdBusy);
    end
  end

  // R10: once asserted in block style, receive ready holds while no pop or flush
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rdyMode == SIG_BLOCK && !rxRdyN && !rxPop && !flushStb.rxFlush)
      |=> (rdyMode != SIG_BLOCK || !rxRdyN));

  // R7: a transmit push in single-character style releases transmit ready
  a_r7_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rdyMode == SIG_CHAR && txPush && !flushStb.txFlush)
      |=> (rdyMode != SIG_CHAR || txRdyN));

  // R8/R10: receive ready is never asserted on an empty receive FIFO
  a_r8_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (flushStb.rxFlush) |=> rxRdyN);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import fifoctl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  output logic [7:0]       cfgRdData,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             holdBusy,
  input  logic             rxTimeout,
  output logic [CNT_W-1:0] rxCount,
  output logic [CNT_W-1:0] txCount,
  output logic             rxTrigHit,
  output logic             rxRdyN,
  output logic             txRdyN
);

  flushStrobe_t flushStb;
  logic         fifoOn;
  rdyMode_e     rdyMode;
  logic [1:0]   trigCode;

  fifoctl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (cfgWrEn),
    .wrData   (cfgWrData),
    .flushStb (flushStb),
    .fifoOn   (fifoOn),
    .rdyMode  (rdyMode),
    .trigCode (trigCode),
    .rdData   (cfgRdData)
  );

  fifoctl_data #(.DEPTH(DEPTH), .CW(CNT_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .flushStb  (flushStb),
    .fifoOn    (fifoOn),
    .rdyMode   (rdyMode),
    .trigCode  (trigCode),
    .rxPush    (rxPush),
    .rxPop     (rxPop),
    .txPush    (txPush),
    .txPop     (txPop),
    .holdBusy  (holdBusy),
    .rxTimeout (rxTimeout),
    .rxCount   (rxCount),
    .txCount   (txCount),
    .rxTrigHit (rxTrigHit),
    .rxRdyN    (rxRdyN),
    .txRdyN    (txRdyN)
  );

endmodule

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic       rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic       holdBusy = 1'b0, rxTimeout = 1'b0;
  logic [4:0] rxCount, txCount;
  logic       rxTrigHit, rxRdyN, txRdyN;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_fifo_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .rxPush(rxPush), .rxPop(rxPop), .txPush(txPush),
    .txPop(txPop), .holdBusy(holdBusy), .rxTimeout(rxTimeout),
    .rxCount(rxCount), .txCount(txCount), .rxTrigHit(rxTrigHit),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic [5:0] ctl;   // {rxPush, rxPop, txPush, txPop, holdBusy, rxTimeout}
    logic [4:0] erx;
    logic [4:0] etx;
    logic       erxn;
    logic       etxn;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 6'b100000, 5'd1, 5'd0, 1'b0, 1'b0},  // R2 R8 push rx
    '{1'b0, 8'h00, 6'b001000, 5'd1, 5'd1, 1'b0, 1'b1},  // R7 push tx
    '{1'b0, 8'h00, 6'b000110, 5'd1, 5'd0, 1'b0, 1'b1},  // R7 holding busy
    '{1'b0, 8'h00, 6'b000000, 5'd1, 5'd0, 1'b0, 1'b0},  // R7 idle
    '{1'b0, 8'h00, 6'b010000, 5'd0, 5'd0, 1'b1, 1'b0},  // R8 pop to empty
    '{1'b0, 8'h00, 6'b010000, 5'd0, 5'd0, 1'b1, 1'b0},  // R2 pop on empty
    '{1'b1, 8'hC9, 6'b000000, 5'd0, 5'd0, 1'b1, 1'b0},  // R9 block, level 14
    '{1'b0, 8'h00, 6'b100000, 5'd1, 5'd0, 1'b1, 1'b0},  // R10 below level
    '{1'b0, 8'h00, 6'b000001, 5'd1, 5'd0, 1'b0, 1'b0},  // R10 timeout
    '{1'b0, 8'h00, 6'b100000, 5'd2, 5'd0, 1'b0, 1'b0},  // R10
    '{1'b0, 8'h00, 6'b010000, 5'd1, 5'd0, 1'b0, 1'b0},  // R10 stays low
    '{1'b0, 8'h00, 6'b010000, 5'd0, 5'd0, 1'b1, 1'b0},  // R10 empty
    '{1'b1, 8'h49, 6'b000000, 5'd0, 5'd0, 1'b1, 1'b0},  // R6 level 4
    '{1'b0, 8'h00, 6'b100000, 5'd1, 5'd0, 1'b1, 1'b0},
    '{1'b0, 8'h00, 6'b100000, 5'd2, 5'd0, 1'b1, 1'b0},
    '{1'b0, 8'h00, 6'b100000, 5'd3, 5'd0, 1'b1, 1'b0},
    '{1'b0, 8'h00, 6'b100000, 5'd4, 5'd0, 1'b0, 1'b0},  // R10 level reached
    '{1'b1, 8'h4F, 6'b101000, 5'd0, 5'd0, 1'b1, 1'b0},  // R3 R4 flush wins
    '{1'b1, 8'h31, 6'b000000, 5'd0, 5'd0, 1'b1, 1'b0}   // R5 unused bits
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic [5:0] ctl);
    @(negedge clk);
    cfgWrEn = wr;
    cfgWrData = wd;
    {rxPush, rxPop, txPush, txPop, holdBusy, rxTimeout} = ctl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rxCount", 8'(rxCount), 8'd0);
    chk("R1 txCount", 8'(txCount), 8'd0);
    chk("R1 cfgRdData", cfgRdData, 8'h00);
    chk("R1 txRdyN", 8'(txRdyN), 8'd0);
    chk("R1 rxRdyN", 8'(rxRdyN), 8'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].wd, VEC[i].ctl);
      chk($sformatf("vec%0d R2 R3 R4 rxCount", i), 8'(rxCount), 8'(VEC[i].erx));
      chk($sformatf("vec%0d R2 R4 txCount", i), 8'(txCount), 8'(VEC[i].etx));
      chk($sformatf("vec%0d R8 R10 rxRdyN", i), 8'(rxRdyN), 8'(VEC[i].erxn));
      chk($sformatf("vec%0d R7 R9 txRdyN", i), 8'(txRdyN), 8'(VEC[i].etxn));
    end

    // R5 readback masks bits 1,2,4,5
    step(1'b1, 8'hFF, 6'b000000);
    chk("R5 readback", cfgRdData, 8'hC9);

    // R9 transmit full in block style, R2 saturation
    for (int k = 0; k < 16; k++) step(1'b0, 8'h00, 6'b001000);
    chk("R9 txCount full", 8'(txCount), 8'd16);
    chk("R9 txRdyN full", 8'(txRdyN), 8'd1);
    step(1'b0, 8'h00, 6'b001000);
    chk("R2 push dropped when full", 8'(txCount), 8'd16);
    step(1'b0, 8'h00, 6'b001100);
    chk("R2 push+pop at full", 8'(txCount), 8'd15);
    chk("R9 txRdyN not full", 8'(txRdyN), 8'd0);

    // R6 trigger levels in block style
    for (int c = 0; c < 4; c++) begin
      int lvl;
      lvl = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
      step(1'b1, {2'(c), 6'b001011}, 6'b000000);
      chk($sformatf("R3 flush code%0d", c), 8'(rxCount), 8'd0);
      for (int k = 0; k < lvl - 1; k++) step(1'b0, 8'h00, 6'b100000);
      chk($sformatf("R6 below level code%0d", c), 8'(rxTrigHit), 8'd0);
      chk($sformatf("R10 below level code%0d", c), 8'(rxRdyN), 8'd1);
      step(1'b0, 8'h00, 6'b100000);
      chk($sformatf("R6 at level code%0d", c), 8'(rxTrigHit), 8'd1);
      chk($sformatf("R10 at level code%0d", c), 8'(rxRdyN), 8'd0);
    end
    chk("R4 tx untouched by rx flush", 8'(txCount), 8'd15);

    // R5 zero write of flush bits keeps counts
    step(1'b1, 8'h00, 6'b000000);
    chk("R5 rx kept", 8'(rxCount), 8'd14);
    chk("R5 tx kept", 8'(txCount), 8'd15);

    // R9 select without enable stays single-character; R6 flag needs enable
    step(1'b1, 8'h0A, 6'b000000);
    step(1'b0, 8'h00, 6'b100000);
    chk("R8 rxRdyN fifo off", 8'(rxRdyN), 8'd0);
    chk("R6 trigHit fifo off", 8'(rxTrigHit), 8'd0);
    chk("R7 txRdyN char style", 8'(txRdyN), 8'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule